// File: doc/BRIEF.md
# Host Interrupt Threshold Controller

This block is the command and status slice of a USB 2.0 host controller that decides when the host is interrupted. It holds a 32-bit command word with three live parts. The first is an 8-bit interrupt threshold code. The second is a bit that lets the schedule engine walk the asynchronous list. The third is a doorbell that software rings to ask the engine to drop its cached asynchronous state. Next to the command word sit a status word and an enable word. Status bits are set by engine events and cleared by software writing ones to them.

Interrupts are paced to microframes. A counter advances on each pulse of `uframe_tick` and reaches a boundary every N ticks, where N is the threshold code read as a number. At a boundary the interrupt output is raised if any enabled status bit is pending. A status bit that becomes pending between boundaries waits for the next boundary. The interrupt output falls as soon as nothing enabled is pending.

The doorbell is a handshake with the schedule engine. Software rings it, and the block shows it on `doorbell`. When the engine pulses `evict_done`, the block sets the async-advance status bit and clears the doorbell on the same clock edge. Register access uses a single-cycle write strobe and a combinational read port. Word addresses are: 0 for the command word, 1 for the status word, 2 for the enable word.

Top module: `uhc_irq_ctl`

## Requirements
- R1: After reset the command word reads 00080000h, the status and enable words read 0, and `irq`, `doorbell` and `sched_en` are 0.
- R2: Command bits 23:16 hold the threshold code. A write of any of 01h, 02h, 04h, 08h, 10h, 20h or 40h reads back unchanged.
- R3: A write of any other threshold code (00h, a code with more than one bit set, or 80h) is stored and read back as 08h.
- R4: The tick counter starts at 0 after reset and restarts after each boundary. A boundary is the N-th tick counted, where N is the stored code taken as a number. If an enabled status bit is pending at that tick's clock edge, `irq` is 1 from the next cycle on. A bit that becomes pending between boundaries does not raise `irq` before the next boundary.
- R5: `irq` returns to 0 one cycle after no status bit is both set and enabled. This happens whether the bit was cleared or its enable was removed.
- R6: Command bit 5 is the schedule enable. It is read/write, resets to 0, and drives `sched_en`.
- R7: Writing the command word with bit 6 = 1 and bit 5 = 1 sets the doorbell (bit 6 and `doorbell`). A write with bit 6 = 1 and bit 5 = 0 leaves it 0. Writing 0 to bit 6 never clears it.
- R8: An `evict_done` pulse while the doorbell is 1 sets status bit 5 and clears the doorbell on the same edge. An `evict_done` pulse while the doorbell is 0 changes nothing.
- R9: Status bits are write-1-to-clear at address 1. When an event sets a bit in the same cycle that a write clears it, the set wins.
- R10: Command bits 31:24, 15:7 and 4:0 always read 0, whatever is written to them.
- R11: The enable word at address 2 has the same layout as the status word (bits 1:0 and 5). A set status bit whose enable is 0 never raises `irq`.
- R12: A pulse on `evt[k]` sets status bit k (k = 0 or 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Word address of the read |
| rd_data | output | 32 | Read data (combinational) |
| uframe_tick | input | 1 | One-cycle pulse per microframe |
| evt | input | 2 | Engine event pulses that set status bits 1:0 |
| evict_done | input | 1 | Engine reports cached asynchronous state evicted |
| sched_en | output | 1 | Asynchronous schedule enable to the engine |
| doorbell | output | 1 | Async-advance doorbell to the engine |
| irq | output | 1 | Paced interrupt request |

## Verification
The hardest case to reach is the longest pacing window. Here a status bit sits pending and enabled for 63 ticks without raising `irq`, and then raises it on exactly the 64th. The bench keeps track of where the counter stands after each earlier boundary. It programs code 40h, raises the event right after a boundary and steps the ticks one at a time, then checks the output after the 63rd and after the 64th. The doorbell path is reached in a similar way. The bench rings the bell with the schedule on and confirms the bell is held. It then pulses `evict_done` and checks that the status bit is set but `irq` stays low until the next tick boundary.

// File: rtl/uhc_irq_pkg.sv
package uhc_irq_pkg;

  localparam int CMD_ADDR = 0;
  localparam int STS_ADDR = 1;
  localparam int ENA_ADDR = 2;

  localparam int THR_LSB   = 16;
  localparam int SCHED_BIT = 5;
  localparam int DOOR_BIT  = 6;
  localparam int AA_BIT    = 5;

  localparam logic [7:0] THR_RESET = 8'h08;
  localparam logic [7:0] THR_MAX   = 8'h40;

  // a legal threshold code has exactly one bit set, at most 40h
  function automatic logic thr_ok(input logic [7:0] code);
    return (code != 8'h00) && ((code & (code - 8'd1)) == 8'h00) && (code <= THR_MAX);
  endfunction

  function automatic logic [7:0] thr_norm(input logic [7:0] code);
    return thr_ok(code) ? code : THR_RESET;
  endfunction

  // a one-hot code is its own window length in microframes
  function automatic int thr_len(input logic [7:0] code);
    return int'(thr_norm(code));
  endfunction

endpackage

// File: rtl/uhc_cmd_reg.sv
module uhc_cmd_reg
  import uhc_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_cmd,
  input  logic [7:0]  wr_thr,
  input  logic        wr_sched,
  input  logic        wr_door,
  input  logic        evict_done,
  output logic [7:0]  thr_q,
  output logic        sched_q,
  output logic        door_q,
  output logic        aa_set,
  output logic [31:0] cmd_word
);

  logic door_ring;

  assign door_ring = wr_cmd && wr_door && wr_sched;
  assign aa_set    = door_q && evict_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q   <= THR_RESET;
      sched_q <= 1'b0;
      door_q  <= 1'b0;
    end else begin
      if (wr_cmd) begin
        thr_q   <= thr_norm(wr_thr);
        sched_q <= wr_sched;
      end
      if (aa_set)         door_q <= 1'b0;
      else if (door_ring) door_q <= 1'b1;
    end
  end

  always_comb begin
    cmd_word                      = '0;
    cmd_word[THR_LSB +: 8]        = thr_q;
    cmd_word[DOOR_BIT]            = door_q;
    cmd_word[SCHED_BIT]           = sched_q;
  end

  // R7: a doorbell only appears together with an enabled schedule
  p_door_needs_sched_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(door_q) |-> sched_q);

  // R8: the handshake clears the doorbell on the acknowledging edge
  p_door_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (door_q && evict_done) |=> !door_q);

  // R3: the stored code is always a legal one
  p_thr_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(thr_q) == 1) && (thr_q <= THR_MAX));

endmodule

// File: rtl/uhc_sts_bank.sv
module uhc_sts_bank
  import uhc_irq_pkg::*;
#(
  parameter int NEVT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_sts,
  input  logic            wr_ena,
  input  logic [31:0]     wr_data,
  input  logic [NEVT-1:0] evt,
  input  logic            aa_set,
  output logic [31:0]     sts_q,
  output logic [31:0]     ena_q,
  output logic            pending
);

  localparam logic [31:0] LIVE_MASK =
    ((32'd1 << NEVT) - 32'd1) | (32'd1 << AA_BIT);

  logic [31:0] set_v;
  logic [31:0] clr_v;

  for (genvar b = 0; b < 32; b++) begin : g_set
    if (b < NEVT) begin : g_evt
      assign set_v[b] = evt[b];
    end else if (b == AA_BIT) begin : g_aa
      assign set_v[b] = aa_set;
    end else begin : g_none
      assign set_v[b] = 1'b0;
    end
  end

  assign clr_v   = wr_sts ? (wr_data & LIVE_MASK) : 32'd0;
  assign pending = |(sts_q & ena_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q <= '0;
      ena_q <= '0;
    end else begin
      sts_q <= ((sts_q & ~clr_v) | set_v) & LIVE_MASK;
      if (wr_ena) ena_q <= wr_data & LIVE_MASK;
    end
  end

  // R8: the handshake leaves the async-advance status set
  p_aa_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    aa_set |=> sts_q[AA_BIT]);

  // R9: a write of one clears the bit unless a set collides
  p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts && wr_data[AA_BIT] && !aa_set) |=> !sts_q[AA_BIT]);

  // R9: a colliding event wins over the clear
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt[0] |=> sts_q[0]);

endmodule

// File: rtl/uhc_irq_pacer.sv
module uhc_irq_pacer
  import uhc_irq_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [7:0] thr,
  input  logic       pending,
  output logic       boundary,
  output logic       irq
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc  = {1'b0, cnt} + 1'b1;
  // >= lets a lowered code close the window on the next tick
  assign boundary = tick && (int'(cnt_inc) >= thr_len(thr));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      irq <= 1'b0;
    end else begin
      if (boundary)  cnt <= '0;
      else if (tick) cnt <= cnt_inc[CNT_W-1:0];
      irq <= boundary ? pending : (irq && pending);
    end
  end

  // R4: the request only rises right after a window boundary
  p_irq_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(boundary));

  // R4: the counter restarts after each boundary
  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (cnt == '0));

  // R5: nothing pending means the request drops
  p_irq_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |=> !irq);

endmodule

// File: rtl/uhc_irq_ctl.sv
module uhc_irq_ctl
  import uhc_irq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int NEVT   = 2,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic              uframe_tick,
  input  logic [NEVT-1:0]   evt,
  input  logic              evict_done,
  output logic              sched_en,
  output logic              doorbell,
  output logic              irq
);

  logic        wr_cmd, wr_sts, wr_ena;
  logic [7:0]  thr_q;
  logic        aa_set;
  logic [31:0] cmd_word, sts_q, ena_q;
  logic        pending, boundary;

  assign wr_cmd = wr_en && (wr_addr == ADDR_W'(CMD_ADDR));
  assign wr_sts = wr_en && (wr_addr == ADDR_W'(STS_ADDR));
  assign wr_ena = wr_en && (wr_addr == ADDR_W'(ENA_ADDR));

  uhc_cmd_reg i_cmd (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_cmd     (wr_cmd),
    .wr_thr     (wr_data[THR_LSB +: 8]),
    .wr_sched   (wr_data[SCHED_BIT]),
    .wr_door    (wr_data[DOOR_BIT]),
    .evict_done (evict_done),
    .thr_q      (thr_q),
    .sched_q    (sched_en),
    .door_q     (doorbell),
    .aa_set     (aa_set),
    .cmd_word   (cmd_word)
  );

  uhc_sts_bank #(.NEVT(NEVT)) i_sts (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_sts  (wr_sts),
    .wr_ena  (wr_ena),
    .wr_data (wr_data),
    .evt     (evt),
    .aa_set  (aa_set),
    .sts_q   (sts_q),
    .ena_q   (ena_q),
    .pending (pending)
  );

  uhc_irq_pacer #(.CNT_W(CNT_W)) i_pace (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (uframe_tick),
    .thr      (thr_q),
    .pending  (pending),
    .boundary (boundary),
    .irq      (irq)
  );

  always_comb begin
    if (rd_addr == ADDR_W'(CMD_ADDR))      rd_data = cmd_word;
    else if (rd_addr == ADDR_W'(STS_ADDR)) rd_data = sts_q;
    else if (rd_addr == ADDR_W'(ENA_ADDR)) rd_data = ena_q;
    else                                   rd_data = 32'd0;
  end

  // R10: unused command bits never read back as one
  p_cmd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_word[31:24] == 8'h00) && (cmd_word[15:7] == 9'h000) && (cmd_word[4:0] == 5'h00));

endmodule

// File: tb/test_uhc_irq_ctl.sv
module test_uhc_irq_ctl;

  localparam int CLK_PERIOD = 10;
  localparam int PINS = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        uframe_tick = 1'b0;
  logic [1:0]  evt = '0;
  logic        evict_done = 1'b0;
  logic        sched_en, doorbell, irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       req;
  } exp_t;

  exp_t q[$];
  event chk_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  uhc_irq_ctl i_uhc_irq_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .uframe_tick(uframe_tick), .evt(evt), .evict_done(evict_done),
    .sched_en(sched_en), .doorbell(doorbell), .irq(irq)
  );

  // monitor: pops expectations and compares with what the design shows
  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        exp_t it;
        logic [31:0] act;
        it = q.pop_front();
        act = (it.kind == PINS) ? {29'd0, doorbell, sched_en, irq} : rd_data;
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s kind=%0d actual=%08h expected=%08h", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  // driver side: kind 0..2 reads a word, kind 3 samples {doorbell,sched_en,irq}
  task automatic expect_val(input int kind, input logic [31:0] exp, input string req);
    exp_t it;
    if (kind != PINS) rd_addr = 2'(kind);
    #1;
    it.kind = kind; it.exp = exp; it.req = req;
    q.push_back(it);
    -> chk_ev;
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); uframe_tick = 1'b1;
      @(negedge clk); uframe_tick = 1'b0;
    end
  endtask

  task automatic pulse_evt(input int k);
    @(negedge clk); evt[k] = 1'b1;
    @(negedge clk); evt = '0;
  endtask

  task automatic pulse_evict();
    @(negedge clk); evict_done = 1'b1;
    @(negedge clk); evict_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] codes [7];
    codes = '{8'h01, 8'h02, 8'h04, 8'h08, 8'h10, 8'h20, 8'h40};
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    expect_val(0, 32'h0008_0000, "R1 cmd reset");
    expect_val(1, 32'h0, "R1 sts reset");
    expect_val(2, 32'h0, "R1 ena reset");
    expect_val(PINS, 32'h0, "R1 pins reset (R6 sched 0)");

    // R10 reserved and hardwired bits
    wr(0, 32'hFF08_FF9F);
    expect_val(0, 32'h0008_0000, "R10 reserved bits read 0");
    expect_val(PINS, 32'h0, "R10 pins unchanged");

    // R2 legal codes
    foreach (codes[i]) begin
      wr(0, {8'h00, codes[i], 16'h0000});
      expect_val(0, {8'h00, codes[i], 16'h0000}, "R2 legal code readback");
    end

    // R3 illegal codes become 08h
    wr(0, 32'h0003_0000);
    expect_val(0, 32'h0008_0000, "R3 code 03h");
    wr(0, 32'h0000_0000);
    expect_val(0, 32'h0008_0000, "R3 code 00h");
    wr(0, 32'h0080_0000);
    expect_val(0, 32'h0008_0000, "R3 code 80h");

    // R6 schedule enable
    wr(0, 32'h0008_0020);
    expect_val(0, 32'h0008_0020, "R6 sched bit readback");
    expect_val(PINS, 32'h2, "R6 sched_en pin");

    // R11 disabled status bit never interrupts; R12 event sets status
    wr(2, 32'h0000_0001);
    expect_val(2, 32'h1, "R11 enable readback");
    pulse_evt(1);
    expect_val(1, 32'h2, "R12 evt1 sets bit1");
    ticks(8);
    expect_val(PINS, 32'h2, "R11 masked bit gives no irq");
    wr(1, 32'h0000_0002);
    expect_val(1, 32'h0, "R9 w1c clears bit1");

    // R4 default window of 8 ticks
    pulse_evt(0);
    expect_val(1, 32'h1, "R12 evt0 sets bit0");
    ticks(7);
    expect_val(PINS, 32'h2, "R4 no irq before 8th tick");
    ticks(1);
    expect_val(PINS, 32'h3, "R4 irq at 8th tick");

    // R5 drop after clear
    wr(1, 32'h0000_0001);
    idle(1);
    expect_val(PINS, 32'h2, "R5 irq drops after w1c");

    // R4 window of 2
    wr(0, 32'h0002_0020);
    pulse_evt(0);
    ticks(1);
    expect_val(PINS, 32'h2, "R4 code 02h first tick");
    ticks(1);
    expect_val(PINS, 32'h3, "R4 code 02h second tick");
    wr(1, 32'h0000_0001);
    idle(1);
    expect_val(PINS, 32'h2, "R5 drop code 02h");

    // R4 window of 64
    wr(0, 32'h0040_0020);
    pulse_evt(0);
    ticks(63);
    expect_val(PINS, 32'h2, "R4 code 40h no irq at 63");
    ticks(1);
    expect_val(PINS, 32'h3, "R4 code 40h irq at 64");
    wr(2, 32'h0000_0000);
    idle(1);
    expect_val(PINS, 32'h2, "R5 drop on enable removal");
    wr(1, 32'h0000_0001);
    wr(2, 32'h0000_0021);
    expect_val(2, 32'h21, "R11 enable bits 0 and 5");

    // R7 doorbell ring and hold
    wr(0, 32'h0001_0020);
    wr(0, 32'h0001_0060);
    expect_val(0, 32'h0001_0060, "R7 doorbell set");
    expect_val(PINS, 32'h6, "R7 doorbell pin");
    wr(0, 32'h0001_0020);
    expect_val(0, 32'h0001_0060, "R7 writing 0 keeps doorbell");

    // R8 handshake
    pulse_evict();
    expect_val(0, 32'h0001_0020, "R8 doorbell cleared");
    expect_val(1, 32'h20, "R8 status bit5 set");
    expect_val(PINS, 32'h2, "R4 async-advance waits for boundary");
    ticks(1);
    expect_val(PINS, 32'h3, "R4 async-advance irq at boundary");
    wr(1, 32'h0000_0020);
    idle(1);
    expect_val(1, 32'h0, "R9 bit5 cleared");
    expect_val(PINS, 32'h2, "R5 drop after bit5 clear");

    // R8 stray acknowledge ignored
    pulse_evict();
    expect_val(1, 32'h0, "R8 evict without doorbell ignored");

    // R7 ring with schedule off is ignored
    wr(0, 32'h0001_0040);
    expect_val(0, 32'h0001_0000, "R7 ring with sched off ignored");
    expect_val(PINS, 32'h0, "R7 doorbell pin stays 0");

    // R9 set wins over clear
    @(negedge clk);
    evt[1] = 1'b1; wr_en = 1'b1; wr_addr = 2'd1; wr_data = 32'h0000_0002;
    @(negedge clk);
    evt = '0; wr_en = 1'b0;
    expect_val(1, 32'h2, "R9 set wins over clear");
    wr(1, 32'h0000_0002);
    expect_val(1, 32'h0, "R9 clear afterwards");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule